// File: doc/BRIEF.md
# Protection Region Match Unit

This block checks every incoming access address against a small, programmable set of protection regions. Each region has a base address, a power-of-two size, an enable flag and an eight-bit slice mask. The mask splits the region into eight equal slices, and any slice can be switched off on its own. An address that lands in a switched-off slice is not claimed by that region. It then falls through to any other enabled region that also covers it. If no region covers it, the access faults.

A lookup is issued by raising `req_valid` with an address. One clock later the block reports whether a region claimed the address, which region won, and whether the access faulted. Regions are programmed through a one-cycle write port that carries the region number and all of its fields together. A global enable input turns checking off. While it is low, every lookup is reported as a hit and none faults.

This block uses no state machine. It is built from a region register file, one comparator per region, a highest-index priority pick, and a registered result stage.

Top module: `prot_region_match`

## Requirements
- R1: A region with size code N (5 bits) spans 2^(N+1) bytes, and the low N+1 bits of its base are ignored. An enabled region covers an address when the two agree above bit N. A region with N below 4 never matches.
- R2: The slice of an address inside a region is addr[N:N-2]. Mask bit 0 governs the lowest-addressed eighth of the region and mask bit 7 the highest-addressed eighth.
- R3: An address in a slice whose mask bit is 1 is not matched by that region. Another enabled region that covers the address may claim it instead.
- R4: When the global enable is high and no region claims the address, the result shows fault=1, hit=0 and region index 0.
- R5: For size codes 4, 5 and 6 (32, 64 and 128 bytes), the mask is ignored and every slice counts as enabled.
- R6: When several regions claim the same address, the one with the highest index is reported.
- R7: While the global enable is low, a lookup reports hit=1, fault=0 and region index 0.
- R8: Results appear on the clock edge after the edge that samples `req_valid`. `rsp_valid` is high for exactly those cycles.
- R9: A region write is applied at the clock edge that samples `wr_en`. A lookup sampled at the next edge sees the new settings.
- R10: After reset, every region is disabled and all result outputs are 0.
- R11: Size code 31 covers the whole 4 GB address space, and its slices come from address bits [31:29].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | Global checking enable |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Address to check |
| wr_en | input | 1 | Region write strobe |
| wr_region | input | 3 | Region number to write |
| wr_base | input | 32 | Region base address |
| wr_size | input | 5 | Size code N |
| wr_enable | input | 1 | Region enable |
| wr_mask | input | 8 | Slice disable mask |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A region claimed the address, or checking is off |
| rsp_fault | output | 1 | No region claimed the address |
| rsp_region | output | 3 | Index of the winning region |

## Verification
Two regions share one base: a 64 KB region and a 512 KB region with slice 0 masked. Lookups in the masked slice tell fall-through to the lower region apart from a wrong claim by the higher one. Lookups in other slices separate correct slice decoding from off-by-one bit selection. Moving the mask to bit 7 and probing the top slice checks the mask's bit order. It also shows that an address nothing else covers gets a fault rather than a silent hit. A fully masked 64-byte region, an undersized size code and a whole-space region probe the size boundaries. Lookups with the global enable off, and a write followed at once by a lookup, cover the bypass and the timing of updates.

// File: rtl/prm_pkg.sv
package prm_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 5;
    localparam int SLICES = 8;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [SLICES-1:0] mask;
    } region_t;
endpackage

// File: rtl/prm_region_regs.sv
module prm_region_regs
    import prm_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_region,
    input  logic [ADDR_W-1:0]               wr_base,
    input  logic [SIZE_W-1:0]               wr_size,
    input  logic                            wr_enable,
    input  logic [SLICES-1:0]               wr_mask,
    output region_t [NUM_REGIONS-1:0]       regs_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en && (int'(wr_region) < NUM_REGIONS)) begin
            regs_q[wr_region] <= '{en: wr_enable, base: wr_base,
                                   size: wr_size, mask: wr_mask};
        end
    end

    // R9: a write lands in the addressed region at the sampling edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(wr_region)].en == $past(wr_enable)) &&
                  (regs_q[$past(wr_region)].mask == $past(wr_mask)));
endmodule

// File: rtl/prm_region_cmp.sv
module prm_region_cmp
    import prm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  region_t           region,
    input  logic [ADDR_W-1:0] addr,
    output logic              match
);
    logic [5:0]        shift_amt;
    logic              size_ok;
    logic              in_range;
    logic              small_size;
    logic [2:0]        slice_sel;
    logic              slice_ok;

    always_comb begin
        shift_amt  = {1'b0, region.size} + 6'd1;
        size_ok    = region.size >= SIZE_W'(4);
        in_range   = ((addr ^ region.base) >> shift_amt) == '0;
        small_size = region.size <= SIZE_W'(6);
        slice_sel  = 3'(addr >> (region.size - SIZE_W'(2)));
        slice_ok   = small_size || !region.mask[slice_sel];
        match      = region.en && size_ok && in_range && slice_ok;
    end

    // R5: the smallest sizes always match inside their span, mask or not
    a_r5_small_ignores_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (region.en && region.size >= SIZE_W'(4) && region.size <= SIZE_W'(6) &&
         ((addr >> shift_amt) == (region.base >> shift_amt))) |-> match);
endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
    import prm_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_region,
    input  logic [31:0]       wr_base,
    input  logic [4:0]        wr_size,
    input  logic              wr_enable,
    input  logic [7:0]        wr_mask,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fault,
    output logic [IDX_W-1:0]  rsp_region
);
    region_t [NUM_REGIONS-1:0] regs_q;
    logic    [NUM_REGIONS-1:0] match_vec;
    logic                      any_match;
    logic    [IDX_W-1:0]       win_idx;

    prm_region_regs #(.NUM_REGIONS(NUM_REGIONS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_region(wr_region),
        .wr_base(wr_base), .wr_size(wr_size), .wr_enable(wr_enable),
        .wr_mask(wr_mask), .regs_q(regs_q)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        prm_region_cmp i_cmp (
            .clk(clk), .rst_n(rst_n), .region(regs_q[g]),
            .addr(req_addr), .match(match_vec[g])
        );
    end

    // highest index wins
    always_comb begin
        any_match = |match_vec;
        win_idx   = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match_vec[i]) win_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_region <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (!req_valid) begin
                rsp_hit    <= 1'b0;
                rsp_fault  <= 1'b0;
                rsp_region <= '0;
            end else if (!prot_en) begin
                rsp_hit    <= 1'b1;
                rsp_fault  <= 1'b0;
                rsp_region <= '0;
            end else begin
                rsp_hit    <= any_match;
                rsp_fault  <= !any_match;
                rsp_region <= any_match ? win_idx : '0;
            end
        end
    end

    // R4: a valid result is either a hit or a fault, never both
    a_r4_hit_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_fault));
    // R7: checking disabled gives a plain hit
    a_r7_bypass_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !prot_en) |=> (rsp_hit && !rsp_fault && rsp_region == '0));
    // R8: result valid follows the request by one edge
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/test_prot_region_match.sv
module test_prot_region_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_region = '0;
    logic [31:0] wr_base = '0;
    logic [4:0]  wr_size = '0;
    logic        wr_enable = 1'b0;
    logic [7:0]  wr_mask = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [2:0]  rsp_region;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    prot_region_match i_prot_region_match (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .req_valid(req_valid),
        .req_addr(req_addr), .wr_en(wr_en), .wr_region(wr_region),
        .wr_base(wr_base), .wr_size(wr_size), .wr_enable(wr_enable),
        .wr_mask(wr_mask), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_region(rsp_region)
    );

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write_region(int r, logic [31:0] b, logic [4:0] n,
                                logic e, logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_region = 3'(r); wr_base = b;
        wr_size = n; wr_enable = e; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // packs {valid, hit, fault, region}
    task automatic lookup(string req, logic [31:0] a, logic hit,
                          logic flt, logic [2:0] idx);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        #1;
        check(req, {rsp_valid, rsp_hit, rsp_fault, rsp_region},
              {1'b1, hit, flt, idx});
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 reset outputs", {rsp_valid, rsp_hit, rsp_fault, rsp_region}, 6'b0);
        lookup("R10 regions disabled after reset", 32'h2000_0000, 1'b0, 1'b1, 3'd0);
        @(posedge clk); #1;
        check("R8 valid drops without request", {5'b0, rsp_valid}, 6'b0);
    endtask

    task automatic t_basic;
        write_region(0, 32'h2000_0000, 5'd15, 1'b1, 8'h00);   // 64 KB
        lookup("R1 inside 64KB region", 32'h2000_1234, 1'b1, 1'b0, 3'd0);
        lookup("R1 just past 64KB region", 32'h2001_0000, 1'b0, 1'b1, 3'd0);
        lookup("R4 far address faults", 32'h9000_0000, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_shared_base;
        write_region(1, 32'h2000_0000, 5'd18, 1'b1, 8'h01);   // 512 KB, slice0 off
        lookup("R3 masked slice falls to region 0", 32'h2000_8000, 1'b1, 1'b0, 3'd0);
        lookup("R2 slice 1 owned by region 1", 32'h2001_0000, 1'b1, 1'b0, 3'd1);
        lookup("R2 slice 4 owned by region 1", 32'h2004_0000, 1'b1, 1'b0, 3'd1);
        write_region(1, 32'h2000_0000, 5'd18, 1'b1, 8'h80);   // top slice off
        lookup("R2 bit7 masks top slice, R4 fault", 32'h2007_0000, 1'b0, 1'b1, 3'd0);
        lookup("R2 slice 6 still owned", 32'h2006_FFFC, 1'b1, 1'b0, 3'd1);
        lookup("R6 overlap gives highest index", 32'h2000_1000, 1'b1, 1'b0, 3'd1);
    endtask

    task automatic t_sizes;
        write_region(2, 32'h4000_0000, 5'd5, 1'b1, 8'hFF);    // 64 B, mask ignored
        lookup("R5 small region ignores mask", 32'h4000_0030, 1'b1, 1'b0, 3'd2);
        lookup("R5 small region bound", 32'h4000_0040, 1'b0, 1'b1, 3'd0);
        write_region(3, 32'h5000_0000, 5'd3, 1'b1, 8'h00);    // invalid size
        lookup("R1 size code below 4 never matches", 32'h5000_0000, 1'b0, 1'b1, 3'd0);
    endtask

    task automatic t_bypass;
        prot_en = 1'b0;
        lookup("R7 global off gives hit", 32'h5000_0000, 1'b1, 1'b0, 3'd0);
        lookup("R7 global off on matched address", 32'h2001_0000, 1'b1, 1'b0, 3'd0);
        prot_en = 1'b1;
    endtask

    task automatic t_whole_space;
        write_region(4, 32'h0000_0000, 5'd31, 1'b1, 8'h01);
        lookup("R11 whole space covers any address", 32'hDEAD_BEEF, 1'b1, 1'b0, 3'd4);
        lookup("R11 slice 0 of 4GB masked", 32'h1000_0000, 1'b0, 1'b1, 3'd0);
        write_region(4, 32'h0000_0000, 5'd31, 1'b0, 8'h00);
        lookup("R9 disable seen on next lookup", 32'hDEAD_BEEF, 1'b0, 1'b1, 3'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_pre: begin end
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_shared_base;
        t_sizes;
        t_bypass;
        t_whole_space;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule